// File: doc/BRIEF.md
# SPI Word Slave with Receive FIFO

This block is a synchronous serial slave for a four-wire SPI bus driven by an external host processor. SPI mode 0 is used: data is sampled on the rising clock edge and shifted on the falling edge. Each transfer moves one word of 8, 16 or 24 bits, most significant bit first. The block shifts a word out on `miso` while it shifts a word in from `mosi`. The serial inputs are brought into the system clock domain through two-flop synchronizers, and clock edges are detected on the synchronized copies.

Received words go into a ten-entry receive FIFO, which holds up to thirty bytes. The local processor can therefore let several words build up before it is interrupted.

The local side works like a small register file:
- a transmit holding register,
- a registered FIFO read port with a fill level,
- four request outputs: receive, transmit, receive overrun and bus error.

A word that completes while the FIFO is full is dropped and sets the overrun request. Releasing slave select partway through a word drops the partial word and sets the bus-error request.

Top module: `spi_word_slave`

## Requirements
- R1: The word length is set by `wlen`: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 24 bits. A received word appears on `rx_data` right-aligned, with the unused upper bits at zero.
- R2: During each word, the low `wlen`-sized part of the transmit word goes out on `miso` most significant bit first. At the same time the word arriving on `mosi` is captured.
- R3: While `ss_n` is high, edges on `sclk` are ignored: no bits are captured and no word enters the FIFO.
- R4: The FIFO holds up to 10 words and returns them in arrival order. `rx_level` gives the number of stored words.
- R5: `rx_req` is high when `rx_level` is at or above the threshold `rx_thr`. A threshold of 0 counts as 1, and a threshold above 10 counts as 10.
- R6: `tx_req` is high while the holding register is empty. A `tx_wr` pulse fills the register and drops `tx_req`. The register empties when its word is loaded into the shifter, which happens when slave select is asserted or when a word completes.
- R7: If the holding register is empty when a load takes place, the previously loaded word is sent again. After reset that word is zero.
- R8: A word that completes while the FIFO holds 10 words is discarded. It sets `ovr_req`, which stays high until an `err_clr` pulse.
- R9: Raising `ss_n` after one or more bits of a word have arrived drops the partial word and sets `berr_req`, which stays high until `err_clr`. The next frame starts at bit zero.
- R10: After reset, `rx_level` is 0, `rx_req` is 0, `tx_req` is 1, `ovr_req` and `berr_req` are 0, and `miso` is 0.
- R11: An `rx_rd` pulse while the FIFO is not empty places the oldest word on `rx_data` one clock later and lowers `rx_level` by one. An `rx_rd` pulse while the FIFO is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| ss_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| wlen | input | 2 | Word length select (see R1) |
| rx_thr | input | 4 | Receive request threshold |
| tx_data | input | 24 | Word to load into the holding register |
| tx_wr | input | 1 | Write strobe for the holding register |
| rx_rd | input | 1 | FIFO read strobe |
| rx_data | output | 24 | Word read from the FIFO, right-aligned |
| rx_level | output | 4 | Number of words in the FIFO |
| rx_req | output | 1 | Receive request |
| tx_req | output | 1 | Transmit request (holding register empty) |
| ovr_req | output | 1 | Sticky receive-overrun request |
| berr_req | output | 1 | Sticky bus-error request |
| err_clr | input | 1 | Clears both sticky requests |

## Verification
The assertions assume the following about the inputs:
- each `sclk` phase lasts several system clocks, so every edge survives the synchronizer and is seen exactly once;
- `ss_n` never changes in the same cycle as an `sclk` edge;
- `wlen` is held steady for the length of a frame.

The bench keeps within these limits by holding every serial phase for eight system clocks and by moving `ss_n` only while `sclk` has been low for a full phase. It changes `wlen` and `rx_thr` only between frames. Random word lengths, word counts, data and skipped transmit writes are combined with directed cases: FIFO overflow, truncated frames and clock activity with the slave not selected.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int WORD_W = 24;
  localparam int BITS_W = $clog2(WORD_W + 1);

  // Number of payload bits for a word-length select code
  function automatic logic [BITS_W-1:0] word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return BITS_W'(8);
      2'd1:    return BITS_W'(16);
      default: return BITS_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic ss_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic ss_act,
  output logic ss_fall,
  output logic ss_rise,
  output logic mosi_s
);
  // Chains carry one extra tap so that edges can be detected
  logic [STAGES:0]   sck_q;
  logic [STAGES:0]   ss_q;
  logic [STAGES-1:0] mo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0;
      ss_q  <= '1;
      mo_q  <= '0;
    end else begin
      sck_q <= {sck_q[STAGES-1:0], sclk};
      ss_q  <= {ss_q[STAGES-1:0], ss_n};
      mo_q  <= {mo_q[STAGES-2:0], mosi};
    end
  end

  assign sclk_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sclk_fall = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign ss_act    = ~ss_q[STAGES-1];
  assign ss_fall   = ~ss_q[STAGES-1] & ss_q[STAGES];
  assign ss_rise   = ss_q[STAGES-1] & ~ss_q[STAGES];
  assign mosi_s    = mo_q[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_word_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              fall,
  input  logic              ss_act,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic              mosi_s,
  input  logic [BITS_W-1:0] nbits,
  input  logic [WORD_W-1:0] load_word,
  output logic              take,
  output logic              done,
  output logic              berr,
  output logic [WORD_W-1:0] rx_word,
  output logic              miso
);
  localparam logic [BITS_W-1:0] C1   = BITS_W'(1);
  localparam logic [WORD_W-1:0] ONE  = WORD_W'(1);
  localparam logic [BITS_W-1:0] FULL = BITS_W'(WORD_W);

  logic [BITS_W-1:0] cnt;
  logic [WORD_W-1:0] rx_sh, tx_sh, aligned, mask;
  logic              skip;
  logic              last;

  assign last    = (cnt == nbits - C1);
  assign done    = rise & ss_act & last;
  assign take    = ss_fall | done;
  assign berr    = ss_rise & (cnt != '0);
  assign mask    = (ONE << nbits) - ONE;
  assign rx_word = {rx_sh[WORD_W-2:0], mosi_s} & mask;
  // Left-align the outgoing word so the shifter's top bit is always the next bit
  assign aligned = load_word << (FULL - nbits);
  assign miso    = tx_sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
      skip  <= 1'b0;
    end else if (!ss_act) begin
      cnt  <= '0;
      skip <= 1'b0;
    end else if (ss_fall) begin
      tx_sh <= aligned;
      cnt   <= '0;
      skip  <= 1'b0;
    end else if (rise) begin
      rx_sh <= {rx_sh[WORD_W-2:0], mosi_s};
      if (last) begin
        cnt   <= '0;
        tx_sh <= aligned;
        skip  <= 1'b1;   // trailing falling edge of the finished word
      end else begin
        cnt <= cnt + C1;
      end
    end else if (fall) begin
      if (skip) skip  <= 1'b0;
      else      tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < nbits);  // R1
  AST_SS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ss_act |=> cnt == '0);  // R3
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PMAX = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] P1   = PTR_W'(1);
  localparam logic [LVL_W-1:0] L1   = LVL_W'(1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_wr, do_rd;

  assign full  = (level == LVL_W'(DEPTH));
  assign do_wr = push & ~full;
  assign do_rd = pop & (level != '0);

  // Storage without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (do_rd) begin
      rdata <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= (wp == PMAX) ? '0 : wp + P1;
      if (do_rd) rp <= (rp == PMAX) ? '0 : rp + P1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + L1;
        2'b01:   level <= level - L1;
        default: level <= level;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);  // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && pop && !push) |=> level == '0);  // R11
endmodule

// File: rtl/spi_word_slave.sv
module spi_word_slave
  import spi_word_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sclk,
  input  logic                         ss_n,
  input  logic                         mosi,
  output logic                         miso,
  input  logic [1:0]                   wlen,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_thr,
  input  logic [WORD_W-1:0]            tx_data,
  input  logic                         tx_wr,
  input  logic                         rx_rd,
  output logic [WORD_W-1:0]            rx_data,
  output logic [$clog2(DEPTH+1)-1:0]   rx_level,
  output logic                         rx_req,
  output logic                         tx_req,
  output logic                         ovr_req,
  output logic                         berr_req,
  input  logic                         err_clr
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic sclk_rise, sclk_fall, ss_act, ss_fall, ss_rise, mosi_s;
  logic take, done, berr, fifo_full;
  logic [WORD_W-1:0] rx_word, hold, last_word, load_word;
  logic              hold_full, hold_full_nx;
  logic [LVL_W-1:0]  thr_eff;

  spi_in_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .ss_act(ss_act),
    .ss_fall(ss_fall), .ss_rise(ss_rise), .mosi_s(mosi_s)
  );

  assign load_word = hold_full ? hold : last_word;

  spi_shift_core u_core (
    .clk(clk), .rst(rst), .rise(sclk_rise), .fall(sclk_fall),
    .ss_act(ss_act), .ss_fall(ss_fall), .ss_rise(ss_rise), .mosi_s(mosi_s),
    .nbits(word_bits(wlen)), .load_word(load_word),
    .take(take), .done(done), .berr(berr), .rx_word(rx_word), .miso(miso)
  );

  rx_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(done), .wdata(rx_word), .pop(rx_rd),
    .rdata(rx_data), .level(rx_level), .full(fifo_full)
  );

  // A write in the same cycle as a load refills the register after the load
  always_comb begin
    hold_full_nx = hold_full;
    if (take)  hold_full_nx = 1'b0;
    if (tx_wr) hold_full_nx = 1'b1;
  end

  always_comb begin
    if (rx_thr == '0)                     thr_eff = LVL_W'(1);
    else if (rx_thr > LVL_W'(DEPTH))      thr_eff = LVL_W'(DEPTH);
    else                                  thr_eff = rx_thr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold      <= '0;
      hold_full <= 1'b0;
      last_word <= '0;
      tx_req    <= 1'b1;
      rx_req    <= 1'b0;
      ovr_req   <= 1'b0;
      berr_req  <= 1'b0;
    end else begin
      if (take)  last_word <= load_word;
      if (tx_wr) hold      <= tx_data;
      hold_full <= hold_full_nx;
      tx_req    <= ~hold_full_nx;
      rx_req    <= (rx_level >= thr_eff);
      if (done && fifo_full) ovr_req  <= 1'b1;
      else if (err_clr)      ovr_req  <= 1'b0;
      if (berr)              berr_req <= 1'b1;
      else if (err_clr)      berr_req <= 1'b0;
    end
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_req && !err_clr) |=> ovr_req);  // R8
  AST_BERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (berr_req && !err_clr) |=> berr_req);  // R9
  AST_TX_FILL: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !tx_req);  // R6
endmodule

// File: tb/spi_word_slave_test.sv
`timescale 1ns/1ps
module spi_word_slave_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [1:0]  wlen = 2'd0;
  logic [3:0]  rx_thr = 4'd1;
  logic [23:0] tx_data = '0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0;
  logic [23:0] rx_data;
  logic [3:0]  rx_level;
  logic        rx_req, tx_req, ovr_req, berr_req;

  int checks = 0;
  int fails  = 0;
  logic [23:0] q[$];
  logic [23:0] last_tx = '0;

  always #2 clk = ~clk;

  spi_word_slave uut (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .wlen(wlen), .rx_thr(rx_thr), .tx_data(tx_data), .tx_wr(tx_wr),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_level(rx_level), .rx_req(rx_req),
    .tx_req(tx_req), .ovr_req(ovr_req), .berr_req(berr_req), .err_clr(err_clr)
  );

  function automatic logic [23:0] wmask(input int nb, input logic [23:0] w);
    return w & ((24'd1 << nb) - 24'd1);
  endfunction

  function automatic int thr_model(input int thr);
    if (thr == 0) return 1;
    if (thr > 10) return 10;
    return thr;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_tx(input logic [23:0] d);
    tx_data = d; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
  endtask

  task automatic open_frame();
    ss_n = 1'b0; tick(8);
  endtask

  task automatic close_frame();
    ss_n = 1'b1; tick(8);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
  endtask

  task automatic shift_word(input int nb, input logic [23:0] mo, output logic [23:0] mi);
    mi = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      mosi = mo[i];
      tick(8);
      mi[i] = miso;
      sclk = 1'b1;
      tick(8);
      sclk = 1'b0;
    end
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) begin
      logic [23:0] e;
      e = q.pop_front();
      rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
      chk(rx_data == e, tag, rx_data, e);
      chk(rx_level == 4'(q.size()), "R11 level after read", rx_level, q.size());
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] mi, mo[3], tw[3], exp_w;
    bit          wr[3];
    int          wl, nb, nw, th;
    logic [23:0] old;
    void'($urandom(32'd4242));

    tick(4); rst = 1'b0; tick(2);
    // R10 reset state
    chk(rx_level == 0, "R10 level", rx_level, 0);
    chk(rx_req == 0, "R10 rx_req", rx_req, 0);
    chk(tx_req == 1, "R10 tx_req", tx_req, 1);
    chk(ovr_req == 0 && berr_req == 0, "R10 errors", {ovr_req, berr_req}, 0);
    chk(miso == 0, "R10 miso", miso, 0);

    // R7: nothing written since reset -> zero word goes out
    wlen = 2'd0; tick(2);
    open_frame();
    shift_word(8, 24'h3C, mi);
    close_frame();
    chk(mi == 0, "R7 underrun after reset", mi, 0);
    q.push_back(24'h3C);
    chk(rx_level == 1, "R4 level one word", rx_level, 1);
    drain("R1 8-bit word");

    // R11: read on empty FIFO has no effect
    old = rx_data;
    rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(1);
    chk(rx_level == 0 && rx_data == old, "R11 empty read", rx_data, old);

    // R3: clock activity while not selected
    for (int k = 0; k < 20; k++) begin
      mosi = 1'($urandom); sclk = ~sclk; tick(8);
    end
    sclk = 1'b0; tick(8);
    chk(rx_level == 0, "R3 unselected clocks", rx_level, 0);
    chk(berr_req == 0, "R3 no bus error", berr_req, 0);

    // Random traffic: R1 R2 R4 R5 R6 R7
    for (int t = 0; t < 30; t++) begin
      wl = int'($urandom % 3); nb = 8 * (wl + 1); nw = 1 + int'($urandom % 3);
      wlen = 2'(wl); tick(2);
      for (int j = 0; j < 3; j++) begin
        mo[j] = 24'($urandom); tw[j] = 24'($urandom); wr[j] = ($urandom % 4) != 0;
      end
      if (wr[0]) begin
        write_tx(tw[0]);
        chk(tx_req == 0, "R6 tx_req after write", tx_req, 0);
      end
      open_frame();
      for (int j = 0; j < nw; j++) begin
        exp_w = wr[j] ? tw[j] : last_tx;
        last_tx = exp_w;
        if (j + 1 < nw && wr[j+1]) write_tx(tw[j+1]);
        shift_word(nb, mo[j], mi);
        chk(mi == wmask(nb, exp_w), wr[j] ? "R2 miso word" : "R7 repeated word",
            mi, wmask(nb, exp_w));
        q.push_back(wmask(nb, mo[j]));
      end
      close_frame();
      chk(tx_req == 1, "R6 tx_req after load", tx_req, 1);
      chk(rx_level == 4'(q.size()), "R4 level", rx_level, q.size());
      th = int'($urandom % 13);
      rx_thr = 4'(th); tick(2);
      chk(rx_req == (q.size() >= thr_model(th)), "R5 threshold", rx_req,
          q.size() >= thr_model(th));
      drain("R1 R4 received word");
    end

    // R8: overflow with 11 bytes
    wlen = 2'd0; tick(2);
    open_frame();
    for (int j = 0; j < 11; j++) begin
      shift_word(8, 24'(j + 16), mi);
      if (q.size() < 10) q.push_back(24'(j + 16));
    end
    close_frame();
    chk(rx_level == 10, "R8 full level", rx_level, 10);
    chk(ovr_req == 1, "R8 overrun set", ovr_req, 1);
    rx_thr = 4'd10; tick(2);
    chk(rx_req == 1, "R5 threshold ten", rx_req, 1);
    drain("R8 kept words");
    chk(ovr_req == 1, "R8 overrun sticky", ovr_req, 1);
    pulse_clr();
    chk(ovr_req == 0, "R8 overrun cleared", ovr_req, 0);

    // R9: truncated word
    rx_thr = 4'd1;
    open_frame();
    shift_word(5, 24'h15, mi);
    close_frame();
    chk(berr_req == 1, "R9 bus error", berr_req, 1);
    chk(rx_level == 0, "R9 partial dropped", rx_level, 0);
    pulse_clr();
    chk(berr_req == 0, "R9 cleared", berr_req, 0);
    open_frame();
    shift_word(8, 24'hA5, mi);
    close_frame();
    chk(berr_req == 0, "R9 clean frame", berr_req, 0);
    q.push_back(24'hA5);
    drain("R9 realigned word");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule